// File: doc/BRIEF.md
# Variable-Rate Bit Packer

This block sits behind an oversampling data-recovery stage. That stage delivers one, two or three freshly recovered bits per cycle. Two bits is the normal case. One bit arrives when the sample point slips past the end of a bit, and three bits arrive when it slips past the start. The packer gathers these bits in the order they were received. Each time ten of them have built up, it hands them downstream as one parallel word with a single-cycle enable.

Both the fast sampling rate and the slower word rate are modelled here on one clock. An input qualifier marks the cycles that carry bits. Over any stretch of cycles the word enable fires once per ten bits accepted, which works out to about one word every five cycles at the nominal two bits per cycle. Bits that have not yet formed a word stay in an accumulator that is wide enough for nine held bits plus a full three-bit delivery.

The control is a two-state machine. In S_EMPTY no bits are held. In S_PARTIAL between one and nine bits are held. Transition T_FILL goes from S_EMPTY to S_PARTIAL when an accepted delivery leaves bits behind. Transition T_DRAIN goes from S_PARTIAL to S_EMPTY when a delivery completes a word with nothing left over. In every other case the state is kept.

Top module: `vrp_packer`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, empties the accumulator, sets the held-bit count to zero, drives `word_vld_o` low and clears `word_o` to zero.
- R2: `word_vld_o` is high for exactly one cycle. It rises in the cycle after the input cycle that brings the number of held bits to ten or more, and it never rises at any other time.
- R3: Bit order is kept from arrival to output. `in_bits[0]` is the earliest bit of a delivery, then `in_bits[1]`, then `in_bits[2]`. The earliest bit held when a word completes lands on `word_o[0]`, and later bits land on higher positions.
- R4: A delivery of 1, 2 or 3 bits, set by `in_cnt`, is accepted. Lines of `in_bits` at positions equal to or above `in_cnt` are ignored, and their values never reach `word_o`.
- R5: A cycle with `in_vld` low, or with `in_cnt` equal to 0, adds no bits, leaves the held bits unchanged and produces no word.
- R6: Bits left over after a word is emitted are kept in order and lead the next word. Across any mix of delivery sizes no bit is lost or repeated. This includes 9 held bits plus a 3-bit delivery.
- R7: After every clock edge the number of held bits is below ten.
- R8: The state is S_EMPTY exactly when no bits are held and S_PARTIAL otherwise, following T_FILL and T_DRAIN as described above.
- R9: Between pulses of `word_vld_o`, `word_o` holds the last word emitted, or zero if no word has been emitted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Qualifies a cycle that carries recovered bits |
| in_cnt | input | 2 | Number of valid bits in `in_bits` (0 to 3) |
| in_bits | input | 3 | Recovered bits, earliest at position 0 |
| word_o | output | 10 | Packed word, earliest bit at position 0 |
| word_vld_o | output | 1 | One-cycle enable marking a new word |

## Verification
The hardest case to reach from the ports is a particular number of held bits meeting a particular delivery size. The worst of these is nine held bits followed by a three-bit delivery that overshoots the word boundary by two. The bench reaches every one of these pairings directly. After each reset it feeds single-bit deliveries to set the held count to each value from zero to nine. It then applies every delivery size with every data pattern and with the ignored lines driven high, and then drains with idle cycles and full deliveries. A long pseudo-random run follows, which mixes sizes, zero counts and idle cycles.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

    // Occupancy states of the packer controller
    typedef enum logic [0:0] {
        S_EMPTY   = 1'b0,
        S_PARTIAL = 1'b1
    } vrp_state_e;

    // Accumulator width needed to absorb one full delivery on top of the
    // largest remainder that can be held without emitting a word
    function automatic int vrp_acc_width(input int word_w, input int max_in);
        return word_w + max_in - 1;
    endfunction

endpackage

// File: rtl/vrp_merge.sv
// Places the valid lanes of a delivery directly above the bits already held.
module vrp_merge #(
    parameter int MAX_IN = 3,
    parameter int ACC_W  = 12,
    parameter int CNT_W  = 4,
    parameter int ICW    = 2
) (
    input  logic [ACC_W-1:0]  acc_q,
    input  logic [CNT_W-1:0]  fill_q,
    input  logic              in_vld,
    input  logic [MAX_IN-1:0] in_bits,
    input  logic [ICW-1:0]    in_cnt,
    output logic [ACC_W-1:0]  merged,
    output logic [CNT_W-1:0]  sum,
    output logic              take
);
    logic [ICW-1:0]    eff_cnt;
    logic [MAX_IN-1:0] gated;

    // Clamp a count beyond the lane count to the lane count
    assign eff_cnt = (32'(in_cnt) > MAX_IN) ? ICW'(MAX_IN) : in_cnt;

    // Each lane passes only when its position is below the delivered count
    for (genvar k = 0; k < MAX_IN; k++) begin : g_lane
        assign gated[k] = in_bits[k] & (k < 32'(eff_cnt));
    end

    assign take   = in_vld && (eff_cnt != '0);
    assign merged = take ? (acc_q | (ACC_W'(gated) << fill_q)) : acc_q;
    assign sum    = take ? (fill_q + CNT_W'(eff_cnt)) : fill_q;
endmodule

// File: rtl/vrp_split.sv
// Decides whether a word is complete and separates it from the remainder.
module vrp_split #(
    parameter int WORD_W = 10,
    parameter int ACC_W  = 12,
    parameter int CNT_W  = 4
) (
    input  logic [ACC_W-1:0]  merged,
    input  logic [CNT_W-1:0]  sum,
    output logic              full,
    output logic [WORD_W-1:0] word_nxt,
    output logic [ACC_W-1:0]  rem_acc,
    output logic [CNT_W-1:0]  rem_fill
);
    assign full     = (sum >= CNT_W'(WORD_W));
    assign word_nxt = merged[WORD_W-1:0];
    assign rem_acc  = merged >> WORD_W;
    assign rem_fill = sum - CNT_W'(WORD_W);
endmodule

// File: rtl/vrp_ctrl.sv
// Occupancy state machine plus the accumulator and output registers.
module vrp_ctrl
    import vrp_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int ACC_W  = 12,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              full,
    input  logic [ACC_W-1:0]  merged,
    input  logic [CNT_W-1:0]  sum,
    input  logic [WORD_W-1:0] word_nxt,
    input  logic [ACC_W-1:0]  rem_acc,
    input  logic [CNT_W-1:0]  rem_fill,
    output logic [ACC_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  fill_q,
    output logic [WORD_W-1:0] word_q,
    output logic              vld_q,
    output vrp_state_e        state_q
);
    vrp_state_e       state_d;
    logic [CNT_W-1:0] fill_d;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        if (take && full) begin
            fill_d = rem_fill;
            acc_d  = rem_acc;
        end else begin
            fill_d = sum;
            acc_d  = merged;
        end
    end

    // Next-state: T_FILL and T_DRAIN
    always_comb begin
        unique case (state_q)
            S_EMPTY:   state_d = (take && fill_d != '0) ? S_PARTIAL : S_EMPTY;
            S_PARTIAL: state_d = (take && fill_d == '0) ? S_EMPTY : S_PARTIAL;
            default:   state_d = S_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_EMPTY;
        else     state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            fill_q <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            fill_q <= fill_d;
            vld_q  <= take && full;
            if (take && full) word_q <= word_nxt;
        end
    end
endmodule

// File: rtl/vrp_packer.sv
module vrp_packer
    import vrp_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int MAX_IN = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic [$clog2(MAX_IN+1)-1:0]  in_cnt,
    input  logic [MAX_IN-1:0]            in_bits,
    output logic [WORD_W-1:0]            word_o,
    output logic                         word_vld_o
);
    localparam int ACC_W = vrp_acc_width(WORD_W, MAX_IN);
    localparam int CNT_W = $clog2(ACC_W + 1);
    localparam int ICW   = $clog2(MAX_IN + 1);

    logic [ACC_W-1:0]  acc_q, merged, rem_acc;
    logic [CNT_W-1:0]  fill_q, sum, rem_fill;
    logic [WORD_W-1:0] word_nxt;
    logic              take, full;
    vrp_state_e        state_q;

    vrp_merge #(.MAX_IN(MAX_IN), .ACC_W(ACC_W), .CNT_W(CNT_W), .ICW(ICW)) merge_i (
        .acc_q   (acc_q),
        .fill_q  (fill_q),
        .in_vld  (in_vld),
        .in_bits (in_bits),
        .in_cnt  (in_cnt),
        .merged  (merged),
        .sum     (sum),
        .take    (take)
    );

    vrp_split #(.WORD_W(WORD_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) split_i (
        .merged   (merged),
        .sum      (sum),
        .full     (full),
        .word_nxt (word_nxt),
        .rem_acc  (rem_acc),
        .rem_fill (rem_fill)
    );

    vrp_ctrl #(.WORD_W(WORD_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .full     (full),
        .merged   (merged),
        .sum      (sum),
        .word_nxt (word_nxt),
        .rem_acc  (rem_acc),
        .rem_fill (rem_fill),
        .acc_q    (acc_q),
        .fill_q   (fill_q),
        .word_q   (word_o),
        .vld_q    (word_vld_o),
        .state_q  (state_q)
    );
endmodule

// File: rtl/vrp_packer_chk.sv
module vrp_packer_chk
    import vrp_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int MAX_IN = 3,
    parameter int CNT_W  = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_vld,
    input logic [$clog2(MAX_IN+1)-1:0] in_cnt,
    input logic [WORD_W-1:0]           word_o,
    input logic                        word_vld_o,
    input logic [CNT_W-1:0]            fill_q,
    input vrp_state_e                  state_q
);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (fill_q == '0 && !word_vld_o && word_o == '0));

    // R2: a pulse needs a real delivery in the previous cycle
    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |-> ($past(in_vld) && $past(in_cnt) != '0));

    // R2: a pulse needs enough bits held plus delivered
    p_emit_count_r2: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |-> (int'($past(fill_q)) + int'($past(in_cnt)) >= WORD_W));

    // R5
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!in_vld || in_cnt == '0) |=> ($stable(fill_q) && !word_vld_o));

    // R7
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
        int'(fill_q) < WORD_W);

    // R8
    p_state_match_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EMPTY) == (fill_q == '0));

    // R9
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !word_vld_o |-> $stable(word_o));
endmodule

bind vrp_packer vrp_packer_chk #(.WORD_W(WORD_W), .MAX_IN(MAX_IN), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .in_cnt     (in_cnt),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .fill_q     (fill_q),
    .state_q    (state_q)
);

// File: tb/vrp_packer_tb_top.sv
module vrp_packer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [1:0] in_cnt = '0;
    logic [2:0] in_bits = '0;
    logic [9:0] word_o;
    logic       word_vld_o;

    int n_vec = 0;
    int n_bad = 0;
    bit sent [0:8191];
    int wr = 0;
    int rd = 0;
    logic [9:0] last_word = '0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    vrp_packer dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_cnt(in_cnt),
        .in_bits(in_bits), .word_o(word_o), .word_vld_o(word_vld_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word_vld_o == 1'b0, "R1 enable after reset", int'(word_vld_o), 0);
        chk(word_o == '0, "R1 word after reset", int'(word_o), 0);
        rst = 1'b0;
        wr = 0; rd = 0; last_word = '0;
    endtask

    // Drive one cycle at a falling edge, check its result at the next one
    task automatic step(input bit v, input int c, input logic [2:0] b);
        logic [9:0] ew;
        bit ev;
        in_vld = v; in_cnt = 2'(c); in_bits = b;
        @(posedge clk);
        @(negedge clk);
        if (v && c != 0)
            for (int k = 0; k < c; k++) begin sent[wr] = b[k]; wr++; end
        ev = (wr - rd) >= 10;
        chk(word_vld_o == ev, (v && c != 0) ? "R2 enable timing" : "R5 idle enable",
            int'(word_vld_o), int'(ev));
        if (ev) begin
            for (int k = 0; k < 10; k++) ew[k] = sent[rd + k];
            rd += 10;
            last_word = ew;
            chk(word_o == ew, "R3 R4 R6 word content", int'(word_o), int'(ew));
        end else begin
            chk(word_o == last_word, "R9 word held", int'(word_o), int'(last_word));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // Every held count 0..9 against every delivery size and pattern
        for (int f = 0; f < 10; f++)
            for (int c = 1; c <= 3; c++)
                for (int p = 0; p < (1 << c); p++) begin
                    logic [2:0] msk;
                    do_reset();
                    for (int i = 0; i < f; i++) step(1'b1, 1, 3'(i % 3 == 0 ? 3'b111 : 3'b110));
                    msk = 3'((1 << c) - 1);
                    // Lines above the count driven high: must be ignored (R4)
                    step(1'b1, c, (3'(p) & msk) | ~msk);
                    step(1'b0, 3, 3'b111);       // R5: qualifier low
                    step(1'b1, 0, 3'b111);       // R5: zero count
                    for (int i = 0; i < 4; i++) step(1'b1, 3, 3'(f + i + p));
                end
        // Long mixed stream, R6
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[7:4] != 4'h0, int'(lf[1:0]), lf[10:8]);
        end
        // Reset in the middle of a partial word drops it (R1)
        step(1'b1, 3, 3'b101);
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 2, 3'b001);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule